// File: doc/BRIEF.md
# Read Leveling Phase Sweep Checker

This block runs the measurement half of read leveling for a multi-lane DRAM data path. The memory has already been switched into its fixed training-pattern read mode. The block then steps a strobe-to-data delay code through every setting of one full phase. At each setting it lets the delay settle and asks for one read burst. It grades the bytes captured on each lane against a strictly alternating pattern of all-ones and all-zeros. All bits of a lane are assumed to share one routing delay, so one byte per lane and beat is enough.

The result is one pass bit per lane and per delay setting. A later stage can read the pass window of each lane from that bitmap and pick a centre. Putting the memory into pattern mode and choosing the final delay are handled elsewhere.

Top module: `rlvl_sweep`

## Requirements
- R1: After reset, `dly_code` is 0, `rd_req` is 0, `done` is 0 and every bit of `pass_map` is 0.
- R2: A `start` accepted while idle or done clears all of `pass_map`, clears `done` and sets `dly_code` to 0. This is visible in the cycle after the clock edge that sampled `start`.
- R3: `settle_cycles` is sampled when `start` is accepted. After each new delay code (including code 0), `rd_req` stays low for exactly `settle_cycles`+1 clock cycles and then rises. `dly_code` does not change while `rd_req` is high.
- R4: The codes 0, 1, … 63 are visited in ascending order, with exactly one read per code. A high `rd_done` while `rd_req` is high ends the read and moves to the next code.
- R5: Lane l carries its byte on `rd_data[8l+7:8l]`. Beats are cycles with `rd_valid` high, `rd_req` high and `rd_done` low. A lane passes a step only if exactly 8 beats arrive before `rd_done`, with beat k equal to 8'hFF for even k and 8'h00 for odd k. The first beat is therefore 8'hFF.
- R6: Lanes are graded independently within the same read. The result for lane l at code c is written to `pass_map[l*64+c]`, and a failing lane does not affect another lane's bit.
- R7: A read with fewer or more than 8 beats clears the bit of the current code on every lane.
- R8: `done` rises in the cycle after the `rd_done` of code 63 and stays high, with `rd_req` low, until the next `start`.
- R9: A `start` that arrives during a sweep is ignored. The sweep continues from its current code and `pass_map` is not cleared.
- R10: Cycles with `rd_valid` low inside a burst are not beats and do not affect grading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new sweep (accepted when idle or done) |
| settle_cycles | input | 8 | Extra settle clocks after each delay change |
| rd_data | input | 32 | Captured read bytes, one per lane |
| rd_valid | input | 1 | `rd_data` holds a burst beat |
| rd_done | input | 1 | Read burst complete handshake |
| dly_code | output | 6 | Strobe-to-data delay code driven to the lanes |
| rd_req | output | 1 | Read burst request, held until `rd_done` |
| pass_map | output | 256 | Pass bits, bit l*64+c for lane l at code c |
| done | output | 1 | Sweep finished |

## Verification
The sweeps are driven with four kinds of stimulus. A clean pattern on every step shows that every code is visited and written. Distinct per-lane pass windows show that lanes are graded separately and that bits land at the right positions. A mix of faults cycles through the other cases: short bursts, long bursts, an inverted pattern starting with 8'h00, a single flipped bit on one lane, and bursts with idle gaps. This mix separates burst-length checking from byte checking, and whole-read failure from single-lane failure. Different settle values and a stray `start` in mid-sweep check the request timing and the sweep order.

// File: rtl/rlvl_pkg.sv
// Shared types for the read leveling sweep.
package rlvl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READ   = 2'd2,
        ST_DONE   = 2'd3
    } rlvl_state_t;

    // Pattern byte expected at a beat, chosen by beat parity.
    function automatic logic [7:0] rlvl_expect(input logic odd_beat);
        return odd_beat ? 8'h00 : 8'hFF;
    endfunction
endpackage

// File: rtl/rlvl_seq.sv
// Sweep sequencer: walks the delay code through all steps, waits the
// settle time, then holds a read request until the read-done handshake.
// Assumes rd_done is only meaningful while rd_req is high.
module rlvl_seq
    import rlvl_pkg::*;
#(
    parameter int STEPS    = 64,
    parameter int SETTLE_W = 8,
    localparam int STEP_W  = $clog2(STEPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                rd_done,
    output logic [STEP_W-1:0]   dly_code,
    output logic                rd_req,
    output logic                done,
    output logic                map_clear,
    output logic                read_close
);
    localparam logic [STEP_W-1:0] LAST_CODE = STEP_W'(STEPS - 1);

    rlvl_state_t         state;
    logic [SETTLE_W-1:0] settle_q;
    logic [SETTLE_W-1:0] wait_cnt;

    // Decoded strobes for the rest of the block.
    always_comb begin
        rd_req     = (state == ST_READ);
        done       = (state == ST_DONE);
        map_clear  = start && ((state == ST_IDLE) || (state == ST_DONE));
        read_close = (state == ST_READ) && rd_done;
    end

    // State, delay code and settle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dly_code <= '0;
            wait_cnt <= '0;
            settle_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state    <= ST_SETTLE;
                        dly_code <= '0;
                        wait_cnt <= '0;
                        settle_q <= settle_cycles;
                    end
                end
                ST_SETTLE: begin
                    if (wait_cnt == settle_q) state <= ST_READ;
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                ST_READ: begin
                    if (rd_done) begin
                        wait_cnt <= '0;
                        if (dly_code == LAST_CODE) begin
                            state <= ST_DONE;
                        end else begin
                            dly_code <= dly_code + 1'b1;
                            state    <= ST_SETTLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_done |=> dly_code == $past(dly_code)); // R3
    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_done && (dly_code != LAST_CODE) |=> dly_code == $past(dly_code) + 1'b1); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R8
endmodule

// File: rtl/rlvl_beat_trk.sv
// Beat tracker: counts accepted beats of the current burst, saturating
// one past the burst length so that long bursts stay detectable.
module rlvl_beat_trk #(
    parameter int BURST  = 8,
    localparam int IDX_W = $clog2(BURST + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic beat_en,
    output logic beat_odd,
    output logic count_ok
);
    localparam logic [IDX_W-1:0] SAT_IDX = IDX_W'(BURST + 1);

    logic [IDX_W-1:0] idx;

    // Parity selects the expected byte; exact count gates a pass.
    always_comb begin
        beat_odd = idx[0];
        count_ok = (idx == IDX_W'(BURST));
    end

    // Beat index, cleared at each burst boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idx <= '0;
        else if (restart)                    idx <= '0;
        else if (beat_en && idx != SAT_IDX)  idx <= idx + 1'b1;
    end

    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_en |=> idx != '0); // R5
endmodule

// File: rtl/rlvl_lane_chk.sv
// Lane grader: compares one lane's byte on every beat against the
// expected pattern and stores a pass bit per delay step.
// Assumes beat_en and read_close are never high in the same cycle.
module rlvl_lane_chk #(
    parameter int STEPS   = 64,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_clear,
    input  logic              restart,
    input  logic              beat_en,
    input  logic [7:0]        exp_byte,
    input  logic [7:0]        lane_byte,
    input  logic              read_close,
    input  logic              count_ok,
    input  logic [STEP_W-1:0] code,
    output logic [STEPS-1:0]  pass_bits
);
    logic match;

    // Running match flag for the burst in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   match <= 1'b1;
        else if (restart)                             match <= 1'b1;
        else if (beat_en && (lane_byte != exp_byte))  match <= 1'b0;
    end

    // Result bitmap, written once per step at the end of the read.
    always_ff @(posedge clk) begin
        if (!rst_n)          pass_bits       <= '0;
        else if (map_clear)  pass_bits       <= '0;
        else if (read_close) pass_bits[code] <= match && count_ok;
    end

    AST_MAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !read_close && !map_clear |=> $stable(pass_bits)); // R6
endmodule

// File: rtl/rlvl_sweep.sv
// Read leveling phase sweep checker top: sequencer, shared beat tracker
// and one grader per byte lane.
module rlvl_sweep
    import rlvl_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int STEPS    = 64,
    parameter int BURST    = 8,
    parameter int SETTLE_W = 8,
    localparam int STEP_W  = $clog2(STEPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SETTLE_W-1:0]    settle_cycles,
    input  logic [LANES*8-1:0]     rd_data,
    input  logic                   rd_valid,
    input  logic                   rd_done,
    output logic [STEP_W-1:0]      dly_code,
    output logic                   rd_req,
    output logic [LANES*STEPS-1:0] pass_map,
    output logic                   done
);
    logic       map_clear;
    logic       read_close;
    logic       restart;
    logic       beat_en;
    logic       beat_odd;
    logic       count_ok;
    logic [7:0] exp_byte;

    // Beat qualification and the pattern byte for this beat.
    always_comb begin
        restart  = map_clear || read_close;
        beat_en  = rd_req && rd_valid && !rd_done;
        exp_byte = rlvl_expect(beat_odd);
    end

    rlvl_seq #(.STEPS(STEPS), .SETTLE_W(SETTLE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .settle_cycles (settle_cycles),
        .rd_done       (rd_done),
        .dly_code      (dly_code),
        .rd_req        (rd_req),
        .done          (done),
        .map_clear     (map_clear),
        .read_close    (read_close)
    );

    rlvl_beat_trk #(.BURST(BURST)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .beat_en  (beat_en),
        .beat_odd (beat_odd),
        .count_ok (count_ok)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rlvl_lane_chk #(.STEPS(STEPS)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .map_clear  (map_clear),
            .restart    (restart),
            .beat_en    (beat_en),
            .exp_byte   (exp_byte),
            .lane_byte  (rd_data[l*8 +: 8]),
            .read_close (read_close),
            .count_ok   (count_ok),
            .code       (dly_code),
            .pass_bits  (pass_map[l*STEPS +: STEPS])
        );
    end
endmodule

// File: tb/test_rlvl_sweep.sv
`timescale 1ns/1ps
module test_rlvl_sweep;
    localparam int LANES = 4;
    localparam int STEPS = 64;
    localparam int BURST = 8;
    localparam int MW    = LANES * STEPS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        settle_cycles = '0;
    logic [LANES*8-1:0] rd_data = '0;
    logic              rd_valid = 1'b0;
    logic              rd_done = 1'b0;
    logic [5:0]        dly_code;
    logic              rd_req;
    logic [MW-1:0]     pass_map;
    logic              done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [MW-1:0] exp_map;

    always #2.5 clk = ~clk;

    rlvl_sweep i_rlvl_sweep (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done),
        .dly_code(dly_code), .rd_req(rd_req), .pass_map(pass_map), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [MW-1:0] act,
                         input logic [MW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One read burst; returns nothing, drives beats then rd_done.
    task automatic do_read(input int nbeats, input logic [LANES-1:0] flip_lanes,
                           input bit invert, input bit gaps);
        for (int k = 0; k < nbeats; k++) begin
            logic [LANES*8-1:0] d;
            for (int l = 0; l < LANES; l++) begin
                logic [7:0] b;
                b = (k % 2 == 0) ? 8'hFF : 8'h00;
                if (invert) b = ~b;
                if (flip_lanes[l] && k == 3) b = b ^ 8'h01;
                d[l*8 +: 8] = b;
            end
            rd_data  = d;
            rd_valid = 1'b1;
            @(negedge clk);
            if (gaps && k == 2) begin
                rd_valid = 1'b0;
                rd_data  = '0;
                @(negedge clk);
                @(negedge clk);
            end
        end
        rd_valid = 1'b0;
        rd_data  = '0;
        rd_done  = 1'b1;
        @(negedge clk);
        rd_done  = 1'b0;
    endtask

    // Full sweep. mode 0: clean; 1: per-lane windows; 2: fault mix.
    task automatic run_sweep(input int mode, input int settle, input int poke_step,
                             input string tag);
        int code_err = 0;
        int settle_err = 0;
        int cnt;
        exp_map = '0;
        settle_cycles = 8'(settle);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(pass_map == '0, {"R2 map cleared ", tag}, pass_map, '0);
        check(done == 1'b0, {"R2 done cleared ", tag}, MW'(done), '0);
        check(dly_code == 6'd0, {"R2 code zero ", tag}, MW'(dly_code), '0);
        cnt = 0;
        while (!rd_req) begin cnt++; @(negedge clk); end
        if (cnt != settle + 1) settle_err++;
        for (int s = 0; s < STEPS; s++) begin
            int nb = BURST;
            logic [LANES-1:0] fl = '0;
            bit inv = 0;
            bit gp = 0;
            if (dly_code != 6'(s)) code_err++;
            if (mode == 1) begin
                for (int l = 0; l < LANES; l++)
                    if (s < 8 + 6*l || s > 20 + 9*l) fl[l] = 1'b1;
            end else if (mode == 2) begin
                case (s % 6)
                    1: nb = BURST - 1;       // R7 short
                    2: nb = BURST + 1;       // R7 long
                    3: inv = 1;              // R5 inverted pattern
                    4: fl[s % LANES] = 1'b1; // R6 one lane bad
                    5: gp = 1;               // R10 gaps
                    default: ;
                endcase
            end
            for (int l = 0; l < LANES; l++)
                exp_map[l*STEPS + s] = (nb == BURST) && !inv && !fl[l];
            do_read(nb, fl, inv, gp);
            if (s != STEPS - 1) begin
                cnt = 0;
                while (!rd_req) begin
                    start = (cnt == 0 && s == poke_step); // R9 stray start
                    cnt++;
                    @(negedge clk);
                end
                start = 1'b0;
                if (cnt != settle + 1) settle_err++;
            end
        end
        check(settle_err == 0, {"R3 settle length ", tag}, MW'(settle_err), '0);
        check(code_err == 0, {"R4 code order ", tag}, MW'(code_err), '0);
        if (poke_step >= 0)
            check(code_err == 0, {"R9 start ignored mid-sweep ", tag}, MW'(code_err), '0);
        check(pass_map == exp_map, {"R5 R6 R7 R10 bitmap ", tag}, pass_map, exp_map);
        check(done == 1'b1, {"R8 done raised ", tag}, MW'(done), MW'(1));
        repeat (5) @(negedge clk);
        check(done == 1'b1 && rd_req == 1'b0, {"R8 done held, no request ", tag},
              MW'({done, rd_req}), MW'(2'b10));
        check(pass_map == exp_map, {"R8 bitmap held ", tag}, pass_map, exp_map);
    endtask

    task automatic test_reset();
        check(dly_code == 6'd0 && rd_req == 1'b0 && done == 1'b0,
              "R1 reset outputs", MW'({dly_code, rd_req, done}), '0);
        check(pass_map == '0, "R1 reset bitmap", pass_map, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_sweep(0, 3, -1, "clean");
        run_sweep(1, 0, -1, "windows");
        run_sweep(2, 7, 10, "faults");
        run_sweep(0, 1, -1, "clean2");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule